// File: doc/BRIEF.md
# Prioritized Power-State Trigger Controller

This block is the decision core of a power-management unit. It tracks which power state the system is in: STANDBY, ACTIVE, RETENTION (suspend to RAM), SAFE, SAFE_RECOVERY, LP_STANDBY and HALTED. On every clock it looks at a set of trigger inputs. These are fault signals, ON and OFF requests, a wake pin, two sleep signals (each one a pin OR a register bit) and four self-clearing software command bits. From the triggers that are legal in the present state, it picks the one with the highest rank.

A fixed table gives each trigger its legal source states, its destination, whether it may abort a running sequence, and whether it may re-enter its own state. The chosen entry issues a one-cycle start pulse with a sequence code on `seq_id`. The external power sequencer answers with `seq_done`. Only the three shutdown triggers may pre-empt a sequence in flight. All other triggers wait until the sequence has finished.

After the to-safe sequence ends, the block steps through SAFE_RECOVERY. There it counts recovery attempts against a programmable limit. It then either returns to STANDBY or locks into HALTED until reset.

Top module: `pwr_trig_ctrl`

## Requirements
- R1: While reset is asserted and after release, `pwr_state` is STANDBY (0). `seq_start`, `seq_busy`, `upd_prep` and `sw_pend` are 0, and `seq_id` is 0. State codes: STANDBY=0, ACTIVE=1, RETENTION=2, SAFE=3, SAFE_RECOVERY=4, LP_STANDBY=5, HALTED=6.
- R2: The ranks from highest to lowest are: immediate shutdown, power error, orderly shutdown, OFF, watchdog error, processor error, software bit 1, software bit 2, ON, wake rising edge, sleep pair 11, sleep pair 01, sleep pair 00, sleep pair 10, software bit 0, software bit 3. Here the sleep pair is written {sleep1, sleep2}. A trigger that is legal in the present state blocks every trigger ranked below it.
- R3: Immediate shutdown, power error and orderly shutdown are each accepted from STANDBY, ACTIVE or RETENTION. Each moves to SAFE and starts sequence 1, 2 or 3 respectively.
- R4: OFF moves STANDBY, ACTIVE or RETENTION to STANDBY with sequence 4. It is ignored while the state is already STANDBY.
- R5: Watchdog error and processor error are legal only in ACTIVE. Each restarts sequence 5 (warm reset) and stays in ACTIVE, and each may fire again once the sequence ends.
- R6: In ACTIVE, software bit 1 starts sequence 6 (runtime self-test) and software bit 2 starts sequence 7 (bus CRC enable). Neither changes the state.
- R7: ON (level), the wake pin's rising edge, and sleep pair 11 each move STANDBY or RETENTION to ACTIVE with sequence 8. Each is ignored in ACTIVE, and a wake pin held high does not fire again.
- R8: In ACTIVE, sleep pair 00 or 10 moves to RETENTION with sequence 9. Sleep pair 01 does nothing. Each sleep signal reads high when its pin or its register bit is high.
- R9: Software bit 0 moves STANDBY or ACTIVE to LP_STANDBY when `lp_sel` is 1, or to STANDBY when `lp_sel` is 0, with sequence 4. Software bit 3 in ACTIVE sets `upd_prep`, which holds until reset, and starts no sequence.
- R10: A pulse on `sw_set[k]` makes `sw_pend[k]` 1 on the next cycle. The bit clears only in the cycle its command is accepted, and it stays set while the command is not legal.
- R11: `seq_start` pulses for one cycle and raises `seq_busy`. `seq_busy` falls on the cycle after `seq_done`. While busy, no trigger other than the three shutdown triggers is accepted.
- R12: A shutdown trigger accepted while busy issues its start at once, even in the cycle that `seq_done` arrives. `seq_busy` stays 1 in that case.
- R13: When the to-safe sequence completes, the state becomes SAFE_RECOVERY for one cycle and the recovery count goes up by one. If the new count is at least `recov_limit`, the state becomes HALTED. Otherwise it becomes STANDBY.
- R14: HALTED and LP_STANDBY are left only by reset. No trigger starts a sequence in either state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imm_shdn | input | 1 | Immediate shutdown request |
| pwr_err | input | 1 | Supply fault of the processor domain |
| ord_shdn | input | 1 | Orderly shutdown request |
| off_req | input | 1 | OFF request |
| wdog_err | input | 1 | Watchdog error |
| cpu_err | input | 1 | Processor error-monitor fault |
| on_req | input | 1 | ON request |
| wake_pin | input | 1 | Wake pin, acted on at its rising edge |
| slp1_pin | input | 1 | Sleep signal 1, pin |
| slp2_pin | input | 1 | Sleep signal 2, pin |
| slp1_reg | input | 1 | Sleep signal 1, register override |
| slp2_reg | input | 1 | Sleep signal 2, register override |
| sw_set | input | 4 | One-cycle pulses that set software command bits 0..3 |
| lp_sel | input | 1 | Selects LP_STANDBY as the target of software bit 0 |
| recov_limit | input | RCNT_W | Recovery attempt limit |
| seq_done | input | 1 | Sequencer finished the running sequence |
| seq_start | output | 1 | One-cycle sequence start |
| seq_id | output | 4 | Code of the latest started sequence |
| seq_busy | output | 1 | A sequence is in flight |
| pwr_state | output | 3 | Present power state |
| upd_prep | output | 1 | Update-prepare indication |
| sw_pend | output | 4 | Pending software command bits |

## Verification
Two events can meet in one cycle: a sequence reports `seq_done`, and a shutdown trigger arrives. The bench provokes this by raising `seq_done` and `pwr_err` at the same clock edge while a to-active sequence is running. It expects a fresh start with code 2, the state SAFE and `seq_busy` still high, rather than a gap in which the busy flag drops. A second case arises when a software command is pending at the same time as a higher-ranked sleep condition. The bench shows that the command stays pending while that condition holds, and that it is acted on in the very cycle the condition clears.

// File: rtl/pwr_trig_pkg.sv
package pwr_trig_pkg;

  localparam int NTRIG   = 16;
  localparam int TIDX_W  = $clog2(NTRIG);
  localparam int NSTATE  = 7;

  typedef enum logic [2:0] {
    PS_STANDBY = 3'd0,
    PS_ACTIVE  = 3'd1,
    PS_RETAIN  = 3'd2,
    PS_SAFE    = 3'd3,
    PS_RECOVER = 3'd4,
    PS_LPSTBY  = 3'd5,
    PS_HALT    = 3'd6
  } pst_e;

  typedef enum logic [3:0] {
    SQ_NONE         = 4'd0,
    SQ_SAFE_SEVERE  = 4'd1,
    SQ_SAFE_PLAIN   = 4'd2,
    SQ_SAFE_ORDERLY = 4'd3,
    SQ_TO_STANDBY   = 4'd4,
    SQ_WARM         = 4'd5,
    SQ_BIST         = 4'd6,
    SQ_CRC          = 4'd7,
    SQ_TO_ACTIVE    = 4'd8,
    SQ_TO_RETAIN    = 4'd9
  } seq_e;

  // trigger slots, lower index = higher rank
  localparam logic [TIDX_W-1:0] TI_IMM     = 4'd0;
  localparam logic [TIDX_W-1:0] TI_PWRERR  = 4'd1;
  localparam logic [TIDX_W-1:0] TI_ORDERLY = 4'd2;
  localparam logic [TIDX_W-1:0] TI_OFF     = 4'd3;
  localparam logic [TIDX_W-1:0] TI_WDOG    = 4'd4;
  localparam logic [TIDX_W-1:0] TI_CPUERR  = 4'd5;
  localparam logic [TIDX_W-1:0] TI_SW1     = 4'd6;
  localparam logic [TIDX_W-1:0] TI_SW2     = 4'd7;
  localparam logic [TIDX_W-1:0] TI_ON      = 4'd8;
  localparam logic [TIDX_W-1:0] TI_WAKE    = 4'd9;
  localparam logic [TIDX_W-1:0] TI_SLP11   = 4'd10;
  localparam logic [TIDX_W-1:0] TI_SLP01   = 4'd11;
  localparam logic [TIDX_W-1:0] TI_SLP00   = 4'd12;
  localparam logic [TIDX_W-1:0] TI_SLP10   = 4'd13;
  localparam logic [TIDX_W-1:0] TI_SW0     = 4'd14;
  localparam logic [TIDX_W-1:0] TI_SW3     = 4'd15;

  // legal-source masks, bit position = state code
  localparam logic [NSTATE-1:0] SRC_SAR = 7'b0000111;
  localparam logic [NSTATE-1:0] SRC_A   = 7'b0000010;
  localparam logic [NSTATE-1:0] SRC_AR  = 7'b0000110;
  localparam logic [NSTATE-1:0] SRC_SA  = 7'b0000011;

  typedef struct packed {
    logic [NSTATE-1:0] src;
    pst_e              dest;
    logic              imm;
    logic              reent;
    logic              nochg;
    logic              lp_alt;
    seq_e              seq;
  } tent_t;

  function automatic tent_t tent(input logic [TIDX_W-1:0] i);
    tent_t e;
    e.src    = '0;
    e.dest   = PS_STANDBY;
    e.imm    = 1'b0;
    e.reent  = 1'b0;
    e.nochg  = 1'b0;
    e.lp_alt = 1'b0;
    e.seq    = SQ_NONE;
    case (i)
      TI_IMM:     begin e.src = SRC_SAR; e.dest = PS_SAFE; e.imm = 1'b1; e.seq = SQ_SAFE_SEVERE;  end
      TI_PWRERR:  begin e.src = SRC_SAR; e.dest = PS_SAFE; e.imm = 1'b1; e.seq = SQ_SAFE_PLAIN;   end
      TI_ORDERLY: begin e.src = SRC_SAR; e.dest = PS_SAFE; e.imm = 1'b1; e.seq = SQ_SAFE_ORDERLY; end
      TI_OFF:     begin e.src = SRC_SAR; e.dest = PS_STANDBY; e.seq = SQ_TO_STANDBY; end
      TI_WDOG,
      TI_CPUERR:  begin e.src = SRC_A; e.dest = PS_ACTIVE; e.reent = 1'b1; e.seq = SQ_WARM; end
      TI_SW1:     begin e.src = SRC_A; e.reent = 1'b1; e.nochg = 1'b1; e.seq = SQ_BIST; end
      TI_SW2:     begin e.src = SRC_A; e.reent = 1'b1; e.nochg = 1'b1; e.seq = SQ_CRC;  end
      TI_ON,
      TI_WAKE,
      TI_SLP11:   begin e.src = SRC_SAR; e.dest = PS_ACTIVE; e.seq = SQ_TO_ACTIVE; end
      TI_SLP01:   begin e.src = SRC_AR; e.nochg = 1'b1; end
      TI_SLP00,
      TI_SLP10:   begin e.src = SRC_A; e.dest = PS_RETAIN; e.seq = SQ_TO_RETAIN; end
      TI_SW0:     begin e.src = SRC_SA; e.dest = PS_STANDBY; e.lp_alt = 1'b1; e.seq = SQ_TO_STANDBY; end
      TI_SW3:     begin e.src = SRC_A; e.nochg = 1'b1; end
      default:    begin e.src = '0; end
    endcase
    return e;
  endfunction

endpackage

// File: rtl/pwr_trig_capture.sv
module pwr_trig_capture
  import pwr_trig_pkg::*;
#(
  parameter int NSW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              imm_shdn,
  input  logic              pwr_err,
  input  logic              ord_shdn,
  input  logic              off_req,
  input  logic              wdog_err,
  input  logic              cpu_err,
  input  logic              on_req,
  input  logic              wake_pin,
  input  logic              slp1_pin,
  input  logic              slp2_pin,
  input  logic              slp1_reg,
  input  logic              slp2_reg,
  input  logic [NSW-1:0]    sw_set,
  input  logic [NSW-1:0]    sw_clr,
  output logic [NTRIG-1:0]  trig,
  output logic [NSW-1:0]    sw_pend
);

  logic           wake_q;
  logic [NSW-1:0] pend_q, pend_d;
  logic           slp1, slp2, wake_rise;

  assign slp1      = slp1_pin | slp1_reg;
  assign slp2      = slp2_pin | slp2_reg;
  assign wake_rise = wake_pin & ~wake_q;

  // a new set wins over a clear in the same cycle
  always_comb begin
    pend_d = (pend_q & ~sw_clr) | sw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q <= 1'b0;
      pend_q <= '0;
    end else begin
      wake_q <= wake_pin;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    trig             = '0;
    trig[TI_IMM]     = imm_shdn;
    trig[TI_PWRERR]  = pwr_err;
    trig[TI_ORDERLY] = ord_shdn;
    trig[TI_OFF]     = off_req;
    trig[TI_WDOG]    = wdog_err;
    trig[TI_CPUERR]  = cpu_err;
    trig[TI_SW1]     = pend_q[1];
    trig[TI_SW2]     = pend_q[2];
    trig[TI_ON]      = on_req;
    trig[TI_WAKE]    = wake_rise;
    trig[TI_SLP11]   = slp1 & slp2;
    trig[TI_SLP01]   = ~slp1 & slp2;
    trig[TI_SLP00]   = ~slp1 & ~slp2;
    trig[TI_SLP10]   = slp1 & ~slp2;
    trig[TI_SW0]     = pend_q[0];
    trig[TI_SW3]     = pend_q[3];
  end

  assign sw_pend = pend_q;

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pend_q) & ~$past(sw_clr)) & ~pend_q) == '0)) else $error("pending bit lost"); // R10

endmodule

// File: rtl/pwr_trig_arbiter.sv
module pwr_trig_arbiter
  import pwr_trig_pkg::*;
(
  input  logic [NTRIG-1:0]  trig,
  input  pst_e              cur,
  input  logic              busy,
  input  logic              lp_sel,
  output logic              hit,
  output logic [TIDX_W-1:0] idx,
  output pst_e              dest,
  output seq_e              seq,
  output logic              nochg
);

  logic [NTRIG-1:0] valid;
  logic [NTRIG-1:0] nochg_a;
  pst_e             edest [NTRIG];
  seq_e             seq_a [NTRIG];

  for (genvar gi = 0; gi < NTRIG; gi++) begin : g_ent
    localparam tent_t ENT = tent(TIDX_W'(gi));
    assign edest[gi]   = (ENT.lp_alt && lp_sel) ? PS_LPSTBY : ENT.dest;
    assign seq_a[gi]   = ENT.seq;
    assign nochg_a[gi] = ENT.nochg;
    assign valid[gi]   = trig[gi]
                       & ENT.src[cur]
                       & (ENT.reent | ENT.nochg | (edest[gi] != cur))
                       & (~busy | ENT.imm);
  end

  // fixed rank: the lowest index among legal triggers wins
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NTRIG - 1; i >= 0; i--) begin
      if (valid[i]) begin
        hit = 1'b1;
        idx = TIDX_W'(i);
      end
    end
  end

  assign dest  = edest[idx];
  assign seq   = seq_a[idx];
  assign nochg = nochg_a[idx];

endmodule

// File: rtl/pwr_trig_recov.sv
module pwr_trig_recov #(
  parameter int RCNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic [RCNT_W-1:0] limit,
  output logic              reach
);

  localparam logic [RCNT_W-1:0] CNT_MAX = '1;

  logic [RCNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  end

  assign reach = (cnt_d >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (inc) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/pwr_trig_ctrl.sv
module pwr_trig_ctrl
  import pwr_trig_pkg::*;
#(
  parameter int RCNT_W = 4,
  localparam int NSW   = 4,
  localparam int SQ_W  = $bits(seq_e),
  localparam int ST_W  = $bits(pst_e)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              imm_shdn,
  input  logic              pwr_err,
  input  logic              ord_shdn,
  input  logic              off_req,
  input  logic              wdog_err,
  input  logic              cpu_err,
  input  logic              on_req,
  input  logic              wake_pin,
  input  logic              slp1_pin,
  input  logic              slp2_pin,
  input  logic              slp1_reg,
  input  logic              slp2_reg,
  input  logic [NSW-1:0]    sw_set,
  input  logic              lp_sel,
  input  logic [RCNT_W-1:0] recov_limit,
  input  logic              seq_done,
  output logic              seq_start,
  output logic [SQ_W-1:0]   seq_id,
  output logic              seq_busy,
  output logic [ST_W-1:0]   pwr_state,
  output logic              upd_prep,
  output logic [NSW-1:0]    sw_pend
);

  // reset: asserted at once, released after two clocks
  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  logic [NTRIG-1:0]  trig;
  logic [NSW-1:0]    sw_clr;
  logic              hit, a_nochg, rec_inc, rec_reach;
  logic [TIDX_W-1:0] a_idx;
  pst_e              a_dest;
  seq_e              a_seq;

  pst_e st_q, st_d;
  seq_e id_q, id_d;
  logic busy_q, busy_d, start_q, start_d, upd_q, upd_d;

  pwr_trig_capture #(.NSW(NSW)) u_cap (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .imm_shdn (imm_shdn),
    .pwr_err  (pwr_err),
    .ord_shdn (ord_shdn),
    .off_req  (off_req),
    .wdog_err (wdog_err),
    .cpu_err  (cpu_err),
    .on_req   (on_req),
    .wake_pin (wake_pin),
    .slp1_pin (slp1_pin),
    .slp2_pin (slp2_pin),
    .slp1_reg (slp1_reg),
    .slp2_reg (slp2_reg),
    .sw_set   (sw_set),
    .sw_clr   (sw_clr),
    .trig     (trig),
    .sw_pend  (sw_pend)
  );

  pwr_trig_arbiter u_arb (
    .trig   (trig),
    .cur    (st_q),
    .busy   (busy_q),
    .lp_sel (lp_sel),
    .hit    (hit),
    .idx    (a_idx),
    .dest   (a_dest),
    .seq    (a_seq),
    .nochg  (a_nochg)
  );

  pwr_trig_recov #(.RCNT_W(RCNT_W)) u_rec (
    .clk   (clk),
    .rst_n (rst_i_n),
    .inc   (rec_inc),
    .limit (recov_limit),
    .reach (rec_reach)
  );

  // software bits are consumed in the cycle they are accepted
  assign sw_clr[0] = hit && (a_idx == TI_SW0);
  assign sw_clr[1] = hit && (a_idx == TI_SW1);
  assign sw_clr[2] = hit && (a_idx == TI_SW2);
  assign sw_clr[3] = hit && (a_idx == TI_SW3);

  always_comb begin
    st_d    = st_q;
    id_d    = id_q;
    busy_d  = busy_q;
    start_d = 1'b0;
    upd_d   = upd_q;
    rec_inc = 1'b0;
    if (hit) begin
      st_d = a_nochg ? st_q : a_dest;
      if (a_seq != SQ_NONE) begin
        start_d = 1'b1;
        id_d    = a_seq;
        busy_d  = 1'b1;
      end
      if (a_idx == TI_SW3) upd_d = 1'b1;
    end else if (busy_q && seq_done) begin
      busy_d = 1'b0;
      if (st_q == PS_SAFE) st_d = PS_RECOVER;
    end else if (st_q == PS_RECOVER) begin
      rec_inc = 1'b1;
      st_d    = rec_reach ? PS_HALT : PS_STANDBY;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q    <= PS_STANDBY;
      id_q    <= SQ_NONE;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      upd_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      id_q    <= id_d;
      busy_q  <= busy_d;
      start_q <= start_d;
      upd_q   <= upd_d;
    end
  end

  assign seq_start = start_q;
  assign seq_id    = id_q;
  assign seq_busy  = busy_q;
  assign pwr_state = st_q;
  assign upd_prep  = upd_q;

  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(busy_q) |-> start_q) else $error("busy without start"); // R11
  AST_ABORT_TO_SAFE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (start_q && $past(busy_q)) |-> (st_q == PS_SAFE)) else $error("non-shutdown start while busy"); // R12
  AST_SAFE_ENTRY_START: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q == PS_SAFE && $past(st_q) != PS_SAFE) |-> start_q) else $error("SAFE without sequence"); // R3
  AST_RECOVER_EXIT: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q == PS_RECOVER) |=> (st_q == PS_HALT || st_q == PS_STANDBY)) else $error("recovery exit"); // R13
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q == PS_HALT) |=> (st_q == PS_HALT && !start_q)) else $error("left HALTED"); // R14
  AST_LPSTBY_STICKY: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q == PS_LPSTBY && !busy_q) |=> (st_q == PS_LPSTBY && !start_q)) else $error("left LP_STANDBY"); // R14
  AST_SW3_SETS_UPD: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(sw_pend[3]) |-> upd_q) else $error("update bit consumed without flag"); // R9

endmodule

// File: tb/pwr_trig_ctrl_bench.sv
module pwr_trig_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       imm_shdn, pwr_err, ord_shdn, off_req, wdog_err, cpu_err, on_req;
  logic       wake_pin, slp1_pin, slp2_pin, slp1_reg, slp2_reg, lp_sel, seq_done;
  logic [3:0] sw_set;
  logic [3:0] recov_limit;
  logic       seq_start, seq_busy, upd_prep;
  logic [3:0] seq_id, sw_pend;
  logic [2:0] pwr_state;

  int nchk = 0;
  int nbad = 0;
  bit ended = 1'b0;

  always #10 clk = ~clk;

  pwr_trig_ctrl u_pwr_trig_ctrl (
    .clk(clk), .rst_n(rst_n), .imm_shdn(imm_shdn), .pwr_err(pwr_err),
    .ord_shdn(ord_shdn), .off_req(off_req), .wdog_err(wdog_err), .cpu_err(cpu_err),
    .on_req(on_req), .wake_pin(wake_pin), .slp1_pin(slp1_pin), .slp2_pin(slp2_pin),
    .slp1_reg(slp1_reg), .slp2_reg(slp2_reg), .sw_set(sw_set), .lp_sel(lp_sel),
    .recov_limit(recov_limit), .seq_done(seq_done), .seq_start(seq_start),
    .seq_id(seq_id), .seq_busy(seq_busy), .pwr_state(pwr_state),
    .upd_prep(upd_prep), .sw_pend(sw_pend)
  );

  task automatic chk(input string r, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic done_pulse();
    seq_done = 1'b1;
    tick();
    seq_done = 1'b0;
  endtask

  task automatic sw_cmd(input int b);
    sw_set = 4'(1 << b);
    tick();
    sw_set = '0;
  endtask

  task automatic do_reset();
    imm_shdn = 0; pwr_err = 0; ord_shdn = 0; off_req = 0; wdog_err = 0;
    cpu_err = 0; on_req = 0; wake_pin = 0; slp1_pin = 0; slp2_pin = 1;
    slp1_reg = 0; slp2_reg = 0; lp_sel = 0; seq_done = 0; sw_set = '0;
    recov_limit = 4'd2;
    rst_n = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  task automatic go_active();
    on_req = 1'b1;
    tick();
    on_req = 1'b0;
    done_pulse();
  endtask

  task automatic t_reset();
    imm_shdn = 0; pwr_err = 0; ord_shdn = 0; off_req = 0; wdog_err = 0;
    cpu_err = 0; on_req = 0; wake_pin = 0; slp1_pin = 0; slp2_pin = 1;
    slp1_reg = 0; slp2_reg = 0; lp_sel = 0; seq_done = 0; sw_set = '0;
    recov_limit = 4'd2;
    rst_n = 1'b0;
    repeat (2) tick();
    chk("R1 state in reset", pwr_state, 0);
    chk("R1 start in reset", seq_start, 0);
    chk("R1 busy in reset", seq_busy, 0);
    chk("R1 id in reset", seq_id, 0);
    chk("R1 upd in reset", upd_prep, 0);
    chk("R1 pend in reset", sw_pend, 0);
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R1 state after release", pwr_state, 0);
    chk("R1 start after release", seq_start, 0);
  endtask

  task automatic t_on_off();
    do_reset();
    on_req = 1'b1;
    tick();
    chk("R7 on start", seq_start, 1);
    chk("R7 on id", seq_id, 8);
    chk("R7 on state", pwr_state, 1);
    chk("R11 busy raised", seq_busy, 1);
    on_req = 1'b0; off_req = 1'b1;
    tick();
    chk("R11 single pulse", seq_start, 0);
    chk("R11 off held while busy", pwr_state, 1);
    tick();
    chk("R11 off still held", seq_start, 0);
    done_pulse();
    chk("R11 busy cleared", seq_busy, 0);
    tick();
    chk("R4 off start", seq_start, 1);
    chk("R4 off id", seq_id, 4);
    chk("R4 off state", pwr_state, 0);
    done_pulse();
    tick();
    chk("R4 off ignored in standby", seq_start, 0);
    off_req = 1'b0;
    on_req = 1'b1;
    tick();
    done_pulse();
    tick();
    chk("R7 on ignored in active", seq_start, 0);
    on_req = 1'b0;
  endtask

  task automatic t_wake();
    do_reset();
    wake_pin = 1'b1;
    tick();
    chk("R7 wake start", seq_start, 1);
    chk("R7 wake id", seq_id, 8);
    done_pulse();
    off_req = 1'b1;
    tick();
    off_req = 1'b0;
    done_pulse();
    tick();
    chk("R7 held wake no refire", seq_start, 0);
    chk("R7 held wake state", pwr_state, 0);
    wake_pin = 1'b0;
  endtask

  task automatic t_prio();
    do_reset();
    wdog_err = 1'b1;
    tick();
    chk("R5 wdog ignored in standby", seq_start, 0);
    chk("R5 wdog standby state", pwr_state, 0);
    wdog_err = 1'b0;
    go_active();
    wdog_err = 1'b1; cpu_err = 1'b1;
    tick();
    chk("R5 R2 warm id", seq_id, 5);
    chk("R5 stays active", pwr_state, 1);
    done_pulse();
    tick();
    chk("R5 reentrant restart", seq_start, 1);
    wdog_err = 1'b0; cpu_err = 1'b0;
    done_pulse();
    do_reset();
    imm_shdn = 1; pwr_err = 1; ord_shdn = 1; off_req = 1;
    tick();
    chk("R2 R3 severe wins", seq_id, 1);
    chk("R3 to safe", pwr_state, 3);
    imm_shdn = 0; pwr_err = 0; ord_shdn = 0; off_req = 0;
    done_pulse();
    chk("R13 recover state", pwr_state, 4);
    tick();
    chk("R13 below limit to standby", pwr_state, 0);
  endtask

  task automatic t_sleep();
    do_reset();
    go_active();
    slp2_pin = 1'b0;
    tick();
    chk("R8 pair 00 id", seq_id, 9);
    chk("R8 pair 00 state", pwr_state, 2);
    done_pulse();
    slp1_reg = 1'b1; slp2_reg = 1'b1;
    tick();
    chk("R8 R7 reg override 11 id", seq_id, 8);
    chk("R8 R7 back to active", pwr_state, 1);
    done_pulse();
    slp2_reg = 1'b0;
    tick();
    chk("R8 pair 10 state", pwr_state, 2);
    done_pulse();
    slp1_reg = 1'b0; slp2_pin = 1'b1;
    tick();
    tick();
    chk("R8 pair 01 no action", seq_start, 0);
    chk("R8 pair 01 state", pwr_state, 2);
  endtask

  task automatic t_sw();
    do_reset();
    go_active();
    sw_cmd(1);
    chk("R10 pend visible", sw_pend, 2);
    chk("R10 not yet started", seq_start, 0);
    tick();
    chk("R6 bist id", seq_id, 6);
    chk("R6 no state change", pwr_state, 1);
    chk("R10 pend cleared", sw_pend, 0);
    done_pulse();
    sw_cmd(2);
    tick();
    chk("R6 crc id", seq_id, 7);
    done_pulse();
    sw_cmd(3);
    tick();
    chk("R2 pair 01 blocks sw3", sw_pend, 8);
    chk("R2 upd still low", upd_prep, 0);
    slp1_pin = 1'b1;
    tick();
    chk("R9 upd set", upd_prep, 1);
    chk("R9 sw3 no start", seq_start, 0);
    chk("R9 sw3 consumed", sw_pend, 0);
    sw_cmd(0);
    tick();
    chk("R9 sw0 id", seq_id, 4);
    chk("R9 sw0 to standby", pwr_state, 0);
    slp1_pin = 1'b0;
    done_pulse();
    sw_cmd(0);
    tick();
    chk("R10 stays pending when not legal", sw_pend, 1);
    chk("R10 no start", seq_start, 0);
    lp_sel = 1'b1;
    tick();
    chk("R9 lp target", pwr_state, 5);
    chk("R9 lp start", seq_start, 1);
    done_pulse();
    on_req = 1'b1;
    tick();
    tick();
    chk("R14 lp standby sticky", pwr_state, 5);
    chk("R14 lp no start", seq_start, 0);
    on_req = 1'b0;
  endtask

  task automatic t_abort();
    do_reset();
    on_req = 1'b1;
    tick();
    on_req = 1'b0; ord_shdn = 1'b1;
    tick();
    chk("R12 abort start", seq_start, 1);
    chk("R12 orderly id", seq_id, 3);
    chk("R12 safe state", pwr_state, 3);
    ord_shdn = 1'b0; imm_shdn = 1'b1;
    tick();
    chk("R3 shutdown ignored in safe", seq_start, 0);
    imm_shdn = 1'b0;
    done_pulse();
    chk("R13 recover once", pwr_state, 4);
    tick();
    chk("R13 first attempt standby", pwr_state, 0);
    on_req = 1'b1;
    tick();
    on_req = 1'b0;
    seq_done = 1'b1; pwr_err = 1'b1;
    tick();
    seq_done = 1'b0; pwr_err = 1'b0;
    chk("R12 same-cycle start", seq_start, 1);
    chk("R12 same-cycle id", seq_id, 2);
    chk("R12 same-cycle busy", seq_busy, 1);
    done_pulse();
    chk("R13 recover again", pwr_state, 4);
    tick();
    chk("R13 limit reached halts", pwr_state, 6);
    on_req = 1'b1; imm_shdn = 1'b1;
    tick();
    tick();
    chk("R14 halted sticky", pwr_state, 6);
    chk("R14 halted no start", seq_start, 0);
    on_req = 1'b0; imm_shdn = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      nchk++;
      nbad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_on_off();
    t_wake();
    t_prio();
    t_sleep();
    t_sw();
    t_abort();
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

endmodule